// File: doc/BRIEF.md
# Exception Entry State Calculator

This block works out the machine state a 64-bit processor with a hypervisor privilege level takes on when an exception is delivered. A pulse on `start` samples the exception code, the current machine state register (MSR), the partition control fields, the hypervisor interrupt endian bit, the processor model and a flag saying whether hypervisor mode is implemented. One cycle later `done` pulses and the registered results appear: the handler's new MSR, the handler vector address, which save-register pair receives the return state (normal or hypervisor), the MSR image to save, and an error flag. The results hold until the next `start`.

The outcome comes from several rules that interact. Partition control decides whether an external interrupt goes to the hypervisor. A relocated vector offset (the alternate interrupt location, AIL) is applied only when translation is on and the exception does not move the processor into hypervisor mode. The handler's endianness depends on the model and on the privilege of the target. Three models are supported: a legacy model, a middle model that honours the external-interrupt selector and the endian rules, and a newest model that also honours AIL and the hypervisor endian bit.

Top module: `exc_entry_calc`

## Requirements
- R1: The new MSR starts as the current MSR with everything cleared except the machine-check-enable bit (bit 12) and the hypervisor bit (bit 60); the rules below then modify it.
- R2: The saved MSR is the current MSR with the bits of mask 0x783F0000 cleared.
- R3: On an external interrupt (code 4) with the middle (model 1) or newest (model 2) model and `lp_ext_guest` = 0, the new MSR gets the hypervisor bit set and the recoverable bit (bit 1) copied from the current MSR, and `use_hv_pair` is 1; with `lp_ext_guest` = 1, or on the legacy model (model 0, and model 3 which acts as legacy), none of this happens.
- R4: System reset (code 0) and machine check (code 1) set the hypervisor bit and suppress AIL; machine check also clears machine-check-enable in the new MSR.
- R5: Hypervisor data storage (code 7), hypervisor instruction storage (code 8) and hypervisor decrementer (code 6) select the hypervisor pair, set the hypervisor bit and copy the recoverable bit; the two storage codes also suppress AIL.
- R6: A system call (code 5) sets the hypervisor bit only when `sc_level` equals 1.
- R7: AIL is taken from `lp_ail` only on the newest model (0 otherwise) and is suppressed when the current MSR has instruction translation (bit 5) or data translation (bit 4) off, or when the new MSR has the hypervisor bit set while the current MSR does not.
- R8: An effective AIL other than 0 sets bits 5 and 4 in the new MSR; AIL 2 ORs 0x18000 into the vector, AIL 3 ORs 0xC000000000004000 into the vector, and AIL 1 raises `err`.
- R9: On the middle model, little-endian (bit 0) is set in the new MSR when its hypervisor bit is clear and `lp_ile` is 1; on the newest model it is set from `hv_ile` when the new MSR's hypervisor bit is set and from `lp_ile` otherwise; the legacy model never sets it.
- R10: `err` is raised when the hypervisor pair is selected while `hv_present` is 0, and for any code outside 0 to 8.
- R11: The base vector is 0x100 for reset, 0x200 machine check, 0x300 data storage (code 2), 0x400 instruction storage (code 3), 0x500 external, 0xC00 system call, 0x980 hypervisor decrementer, 0xE00 hypervisor data storage, 0xE20 hypervisor instruction storage, and 0 for an unknown code.
- R12: After reset all outputs are 0; results appear with a one-cycle `done` pulse in the cycle after `start` is sampled and hold unchanged while `start` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Sample the inputs and compute a result |
| code | input | 4 | Exception code |
| cur_msr | input | 64 | Current machine state register |
| sc_level | input | 7 | System call level operand |
| lp_ext_guest | input | 1 | Partition selector; 0 sends external interrupts to the hypervisor |
| lp_ail | input | 2 | Partition alternate interrupt location field |
| lp_ile | input | 1 | Partition interrupt little-endian bit |
| hv_ile | input | 1 | Hypervisor interrupt little-endian bit |
| model_sel | input | 2 | Processor model: 0 legacy, 1 middle, 2 newest, 3 legacy |
| hv_present | input | 1 | Hypervisor mode implemented |
| done | output | 1 | One-cycle pulse when results are updated |
| new_msr | output | 64 | Handler MSR |
| vector | output | 64 | Handler vector address |
| use_hv_pair | output | 1 | 1 = hypervisor save pair, 0 = normal pair |
| save_msr | output | 64 | MSR image to save |
| err | output | 1 | Invalid combination detected |

## Verification
The hardest outcome to reach is a relocated vector: it needs the newest model, a nonzero AIL field, both translation bits on in the current MSR, a code that does not suppress AIL, and no move into hypervisor mode, which random MSR values rarely combine. Directed cases build it deliberately, for example a system call at level 1 taken from an MSR already in hypervisor mode with both translation bits on, and a hypervisor decrementer taken from hypervisor mode, next to near-identical cases that flip one translation bit or the current hypervisor bit to show the suppression. A reference model in the bench predicts every output on every clock while random traffic covers the remaining combinations.

// File: rtl/exc_entry_pkg.sv
// Package: exc_entry_pkg
// Shared widths, MSR bit positions, exception code and model encodings and
// vector constants for the exception entry calculator.
// Assumes a 64-bit machine state register with the hypervisor bit at 60.
package exc_entry_pkg;

    localparam int XLEN       = 64;
    localparam int CODE_W     = 4;
    localparam int SCLEV_W    = 7;
    localparam int AIL_W      = 2;
    localparam int MODEL_W    = 2;
    localparam int VBASE_W    = 12;

    // MSR bit positions decoded by the rest of the core
    localparam int MSR_HV_BIT = 60;
    localparam int MSR_ME_BIT = 12;
    localparam int MSR_IR_BIT = 5;
    localparam int MSR_DR_BIT = 4;
    localparam int MSR_RI_BIT = 1;
    localparam int MSR_LE_BIT = 0;

    localparam logic [XLEN-1:0] MSR_KEEP_MASK =
        (XLEN'(1) << MSR_ME_BIT) | (XLEN'(1) << MSR_HV_BIT);
    localparam logic [XLEN-1:0] SAVE_MZ_MASK  = XLEN'(64'h0000_0000_783F_0000);
    localparam logic [XLEN-1:0] AIL2_OFFSET   = XLEN'(64'h0000_0000_0001_8000);
    localparam logic [XLEN-1:0] AIL3_OFFSET   = XLEN'(64'hC000_0000_0000_4000);

    typedef enum logic [CODE_W-1:0] {
        EXC_SRESET = 4'd0,
        EXC_MCHECK = 4'd1,
        EXC_DSTOR  = 4'd2,
        EXC_ISTOR  = 4'd3,
        EXC_EXTINT = 4'd4,
        EXC_SYSC   = 4'd5,
        EXC_HDEC   = 4'd6,
        EXC_HDSTOR = 4'd7,
        EXC_HISTOR = 4'd8
    } exc_code_e;

    typedef enum logic [MODEL_W-1:0] {
        MDL_LEGACY = 2'd0,
        MDL_MID    = 2'd1,
        MDL_NEW    = 2'd2,
        MDL_RSVD   = 2'd3
    } model_e;

    // Per-exception routing decision produced by the router
    typedef struct packed {
        logic               set_hv;
        logic               copy_ri;
        logic               clr_me;
        logic               hv_pair;
        logic               ail_kill;
        logic               bad_code;
        logic [VBASE_W-1:0] base_vec;
    } route_t;

endpackage

// File: rtl/exc_route.sv
// Module: exc_route
// Classifies the exception code: which MSR bits it forces, which save pair
// it uses, whether it suppresses the relocated vector, and its base vector.
// Then forms the pre-endian, pre-AIL handler MSR from the current MSR.
// Assumes ext_guest already reflects the model (1 on models without it).
module exc_route
    import exc_entry_pkg::*;
(
    input  logic [CODE_W-1:0]  code,
    input  logic [XLEN-1:0]    cur_msr,
    input  logic [SCLEV_W-1:0] sc_level,
    input  logic               ext_guest,
    output logic [XLEN-1:0]    msr_pre,
    output logic               hv_pair,
    output logic               ail_kill,
    output logic               bad_code,
    output logic [VBASE_W-1:0] base_vec
);

    route_t rt;

    // Decode the exception code into its routing decision
    always_comb begin
        rt = '0;
        case (code)
            EXC_SRESET: begin
                rt.base_vec = 12'h100;
                rt.set_hv   = 1'b1;
                rt.ail_kill = 1'b1;
            end
            EXC_MCHECK: begin
                rt.base_vec = 12'h200;
                rt.set_hv   = 1'b1;
                rt.ail_kill = 1'b1;
                rt.clr_me   = 1'b1;
            end
            EXC_DSTOR: rt.base_vec = 12'h300;
            EXC_ISTOR: rt.base_vec = 12'h400;
            EXC_EXTINT: begin
                rt.base_vec = 12'h500;
                if (!ext_guest) begin
                    rt.set_hv  = 1'b1;
                    rt.copy_ri = 1'b1;
                    rt.hv_pair = 1'b1;
                end
            end
            EXC_SYSC: begin
                rt.base_vec = 12'hC00;
                rt.set_hv   = (sc_level == SCLEV_W'(1));
            end
            EXC_HDEC: begin
                rt.base_vec = 12'h980;
                rt.set_hv   = 1'b1;
                rt.copy_ri  = 1'b1;
                rt.hv_pair  = 1'b1;
            end
            EXC_HDSTOR, EXC_HISTOR: begin
                rt.base_vec = (code == EXC_HDSTOR) ? 12'hE00 : 12'hE20;
                rt.set_hv   = 1'b1;
                rt.copy_ri  = 1'b1;
                rt.hv_pair  = 1'b1;
                rt.ail_kill = 1'b1;
            end
            default: rt.bad_code = 1'b1;
        endcase
    end

    // Apply the forced bits to the retained part of the current MSR
    always_comb begin
        msr_pre = cur_msr & MSR_KEEP_MASK;
        if (rt.set_hv)  msr_pre[MSR_HV_BIT] = 1'b1;
        if (rt.copy_ri) msr_pre[MSR_RI_BIT] = cur_msr[MSR_RI_BIT];
        if (rt.clr_me)  msr_pre[MSR_ME_BIT] = 1'b0;
    end

    assign hv_pair  = rt.hv_pair;
    assign ail_kill = rt.ail_kill;
    assign bad_code = rt.bad_code;
    assign base_vec = rt.base_vec;

endmodule

// File: rtl/exc_finish.sv
// Module: exc_finish
// Completes the handler state: chooses interrupt endianness per model and
// target privilege, qualifies the relocation field against the current
// translation state and hypervisor transition, and builds the vector.
// Assumes ail_req is already zero on models without relocation.
module exc_finish
    import exc_entry_pkg::*;
(
    input  logic [MODEL_W-1:0] model_sel,
    input  logic               cur_ir,
    input  logic               cur_dr,
    input  logic               cur_hv,
    input  logic [XLEN-1:0]    msr_pre,
    input  logic [AIL_W-1:0]   ail_req,
    input  logic               ail_kill,
    input  logic               lp_ile,
    input  logic               hv_ile,
    input  logic [VBASE_W-1:0] base_vec,
    output logic [XLEN-1:0]    msr_out,
    output logic [XLEN-1:0]    vec_out,
    output logic               ail_bad
);

    logic             tgt_hv;
    logic             le_set;
    logic [AIL_W-1:0] ail_eff;

    assign tgt_hv = msr_pre[MSR_HV_BIT];

    // Pick the handler endianness for the selected model
    always_comb begin
        case (model_sel)
            MDL_MID: le_set = !tgt_hv && lp_ile;
            MDL_NEW: le_set = tgt_hv ? hv_ile : lp_ile;
            default: le_set = 1'b0;
        endcase
    end

    // Suppress relocation when translation is off or privilege rises
    always_comb begin
        ail_eff = ail_req;
        if (ail_kill || !cur_ir || !cur_dr || (tgt_hv && !cur_hv))
            ail_eff = '0;
    end

    // Build the final MSR and vector from the qualified relocation value
    always_comb begin
        msr_out = msr_pre;
        vec_out = XLEN'(base_vec);
        ail_bad = 1'b0;
        if (le_set) msr_out[MSR_LE_BIT] = 1'b1;
        if (ail_eff != '0) begin
            msr_out[MSR_IR_BIT] = 1'b1;
            msr_out[MSR_DR_BIT] = 1'b1;
            case (ail_eff)
                2'd2:    vec_out = vec_out | AIL2_OFFSET;
                2'd3:    vec_out = vec_out | AIL3_OFFSET;
                default: ail_bad = 1'b1;
            endcase
        end
    end

endmodule

// File: rtl/exc_entry_calc.sv
// Module: exc_entry_calc (top)
// Computes the state for entering an exception: handler MSR, vector, save
// pair, saved MSR and an error flag. Inputs are sampled on start; results
// are registered one cycle later with a done pulse and held until the next
// start. Assumes inputs are stable in the cycle start is high.
module exc_entry_calc
    import exc_entry_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [CODE_W-1:0]  code,
    input  logic [XLEN-1:0]    cur_msr,
    input  logic [SCLEV_W-1:0] sc_level,
    input  logic               lp_ext_guest,
    input  logic [AIL_W-1:0]   lp_ail,
    input  logic               lp_ile,
    input  logic               hv_ile,
    input  logic [MODEL_W-1:0] model_sel,
    input  logic               hv_present,
    output logic               done,
    output logic [XLEN-1:0]    new_msr,
    output logic [XLEN-1:0]    vector,
    output logic               use_hv_pair,
    output logic [XLEN-1:0]    save_msr,
    output logic               err
);

    logic               newer_mdl;
    logic               ext_guest_eff;
    logic [AIL_W-1:0]   ail_req;
    logic [XLEN-1:0]    msr_pre;
    logic               hv_pair_c;
    logic               ail_kill;
    logic               bad_code;
    logic [VBASE_W-1:0] base_vec;
    logic [XLEN-1:0]    msr_c;
    logic [XLEN-1:0]    vec_c;
    logic               ail_bad;
    logic               err_c;

    // Model-dependent view of the partition control fields
    always_comb begin
        newer_mdl     = (model_sel == MDL_MID) || (model_sel == MDL_NEW);
        ext_guest_eff = newer_mdl ? lp_ext_guest : 1'b1;
        ail_req       = (model_sel == MDL_NEW) ? lp_ail : '0;
    end

    exc_route u_route (
        .code      (code),
        .cur_msr   (cur_msr),
        .sc_level  (sc_level),
        .ext_guest (ext_guest_eff),
        .msr_pre   (msr_pre),
        .hv_pair   (hv_pair_c),
        .ail_kill  (ail_kill),
        .bad_code  (bad_code),
        .base_vec  (base_vec)
    );

    exc_finish u_finish (
        .model_sel (model_sel),
        .cur_ir    (cur_msr[MSR_IR_BIT]),
        .cur_dr    (cur_msr[MSR_DR_BIT]),
        .cur_hv    (cur_msr[MSR_HV_BIT]),
        .msr_pre   (msr_pre),
        .ail_req   (ail_req),
        .ail_kill  (ail_kill),
        .lp_ile    (lp_ile),
        .hv_ile    (hv_ile),
        .base_vec  (base_vec),
        .msr_out   (msr_c),
        .vec_out   (vec_c),
        .ail_bad   (ail_bad)
    );

    // Collect every error source into one flag
    assign err_c = bad_code || ail_bad || (hv_pair_c && !hv_present);

    // Register the results on start and pulse done for one cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done        <= 1'b0;
            new_msr     <= '0;
            vector      <= '0;
            use_hv_pair <= 1'b0;
            save_msr    <= '0;
            err         <= 1'b0;
        end else begin
            done <= start;
            if (start) begin
                new_msr     <= msr_c;
                vector      <= vec_c;
                use_hv_pair <= hv_pair_c;
                save_msr    <= cur_msr & ~SAVE_MZ_MASK;
                err         <= err_c;
            end
        end
    end

endmodule

// File: rtl/exc_entry_calc_chk.sv
// Module: exc_entry_calc_chk
// Temporal checks on the exception entry calculator's ports, bound to the
// top module. Assumes synchronous active-low reset.
module exc_entry_calc_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        start,
    input logic        hv_present,
    input logic        done,
    input logic        nm_hv,
    input logic        nm_ir,
    input logic        nm_dr,
    input logic [2:0]  vec_hi,
    input logic        use_hv_pair,
    input logic [9:0]  save_mz,
    input logic        err
);

    // R12: a sampled start produces done in the next cycle
    a_r12_done_after_start: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> done);

    // R12: no done without a start in the cycle before
    a_r12_no_spurious_done: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> !done);

    // R12: results hold while start stays low
    a_r12_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> ($stable(vec_hi) && $stable(use_hv_pair) && $stable(err)
                    && $stable(nm_hv)));

    // R5: the hypervisor save pair always goes with a hypervisor target
    a_r5_pair_implies_hv: assert property (@(posedge clk) disable iff (!rst_n)
        (done && use_hv_pair) |-> nm_hv);

    // R2: must-be-zero bits never reach the saved MSR
    a_r2_save_masked: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (save_mz == 10'd0));

    // R10: hypervisor pair without hypervisor support is an error
    a_r10_hv_unsupported: assert property (@(posedge clk) disable iff (!rst_n)
        (done && use_hv_pair && !$past(hv_present)) |-> err);

    // R8: a relocated vector comes with both translation bits set
    a_r8_offset_xlate: assert property (@(posedge clk) disable iff (!rst_n)
        (done && (vec_hi != 3'd0)) |-> (nm_ir && nm_dr));

endmodule

bind exc_entry_calc exc_entry_calc_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .hv_present  (hv_present),
    .done        (done),
    .nm_hv       (new_msr[60]),
    .nm_ir       (new_msr[5]),
    .nm_dr       (new_msr[4]),
    .vec_hi      (vector[16:14]),
    .use_hv_pair (use_hv_pair),
    .save_mz     ({save_msr[30:27], save_msr[21:16]}),
    .err         (err)
);

// File: tb/tb_exc_entry_calc.sv
module tb_exc_entry_calc;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [3:0]  code = '0;
    logic [63:0] cur_msr = '0;
    logic [6:0]  sc_level = '0;
    logic        lp_ext_guest = 1'b0;
    logic [1:0]  lp_ail = '0;
    logic        lp_ile = 1'b0;
    logic        hv_ile = 1'b0;
    logic [1:0]  model_sel = '0;
    logic        hv_present = 1'b1;
    logic        done;
    logic [63:0] new_msr, vector, save_msr;
    logic        use_hv_pair, err;

    int n_checks = 0;
    int n_errors = 0;
    int cycles = 0;
    bit checking = 1'b0;
    string cur_tag = "R12";

    localparam logic [63:0] B_HV = 64'h1000_0000_0000_0000;
    localparam logic [63:0] B_ME = 64'h0000_0000_0000_1000;
    localparam logic [63:0] B_IR = 64'h20;
    localparam logic [63:0] B_DR = 64'h10;
    localparam logic [63:0] B_RI = 64'h2;
    localparam logic [63:0] B_LE = 64'h1;

    always #4 clk = ~clk;

    exc_entry_calc dut (
        .clk(clk), .rst_n(rst_n), .start(start), .code(code), .cur_msr(cur_msr),
        .sc_level(sc_level), .lp_ext_guest(lp_ext_guest), .lp_ail(lp_ail),
        .lp_ile(lp_ile), .hv_ile(hv_ile), .model_sel(model_sel),
        .hv_present(hv_present), .done(done), .new_msr(new_msr), .vector(vector),
        .use_hv_pair(use_hv_pair), .save_msr(save_msr), .err(err)
    );

    // Reference model written from the requirements
    function automatic void ref_model(
        input logic [3:0] c, input logic [63:0] m, input logic [6:0] lev,
        input logic sel_in, input logic [1:0] ail_in, input logic ile,
        input logic hile, input logic [1:0] mdl, input logic hvp,
        output logic [63:0] nm, output logic [63:0] vec, output logic [63:0] sm,
        output logic hp, output logic er);
        int  ail;
        bit  sel;
        bit  newer;
        bit  le;
        newer = (mdl == 2'd1) || (mdl == 2'd2);
        sel   = newer ? sel_in : 1'b1;
        ail   = (mdl == 2'd2) ? int'(ail_in) : 0;
        nm = m & (B_ME | B_HV);
        hp = 1'b0; er = 1'b0; vec = 64'h0;
        case (c)
            4'd0: begin vec = 64'h100; nm |= B_HV; ail = 0; end
            4'd1: begin vec = 64'h200; nm |= B_HV; nm &= ~B_ME; ail = 0; end
            4'd2: vec = 64'h300;
            4'd3: vec = 64'h400;
            4'd4: begin
                vec = 64'h500;
                if (!sel) begin nm |= B_HV | (m & B_RI); hp = 1'b1; end
            end
            4'd5: begin vec = 64'hC00; if (lev == 7'd1) nm |= B_HV; end
            4'd6: begin vec = 64'h980; nm |= B_HV | (m & B_RI); hp = 1'b1; end
            4'd7: begin vec = 64'hE00; nm |= B_HV | (m & B_RI); hp = 1'b1; ail = 0; end
            4'd8: begin vec = 64'hE20; nm |= B_HV | (m & B_RI); hp = 1'b1; ail = 0; end
            default: er = 1'b1;
        endcase
        if ((m & B_IR) == 0 || (m & B_DR) == 0 ||
            ((nm & B_HV) != 0 && (m & B_HV) == 0)) ail = 0;
        le = 1'b0;
        if (mdl == 2'd1) le = ((nm & B_HV) == 0) && ile;
        if (mdl == 2'd2) le = ((nm & B_HV) != 0) ? hile : ile;
        if (le) nm |= B_LE;
        if (ail != 0) begin
            nm |= B_IR | B_DR;
            if (ail == 2) vec |= 64'h18000;
            else if (ail == 3) vec |= 64'hC000_0000_0000_4000;
            else er = 1'b1;
        end
        if (hp && !hvp) er = 1'b1;
        sm = m & ~64'h783F_0000;
    endfunction

    // Expected registers advanced by the reference model on each clock
    logic        e_done;
    logic [63:0] e_nm, e_vec, e_sm;
    logic        e_hp, e_er;
    logic [63:0] t_nm, t_vec, t_sm;
    logic        t_hp, t_er;

    always @(posedge clk) begin
        if (!rst_n) begin
            e_done <= 1'b0; e_nm <= '0; e_vec <= '0; e_sm <= '0;
            e_hp <= 1'b0; e_er <= 1'b0;
        end else begin
            e_done <= start;
            if (start) begin
                ref_model(code, cur_msr, sc_level, lp_ext_guest, lp_ail, lp_ile,
                          hv_ile, model_sel, hv_present, t_nm, t_vec, t_sm, t_hp, t_er);
                e_nm <= t_nm; e_vec <= t_vec; e_sm <= t_sm;
                e_hp <= t_hp; e_er <= t_er;
            end
        end
    end

    task automatic chk(input string what, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s %s actual=%h expected=%h", cur_tag, what, act, exp);
        end
    endtask

    // Compare every output with the model away from the active edge
    always @(negedge clk) begin
        if (rst_n && checking) begin
            chk("done", 64'(done), 64'(e_done));
            chk("new_msr", new_msr, e_nm);
            chk("vector", vector, e_vec);
            chk("save_msr", save_msr, e_sm);
            chk("use_hv_pair", 64'(use_hv_pair), 64'(e_hp));
            chk("err", 64'(err), 64'(e_er));
        end
    end

    task automatic issue(input string tag, input logic [3:0] c, input logic [63:0] m,
                         input logic [6:0] lev, input logic sel, input logic [1:0] a,
                         input logic ile, input logic hile, input logic [1:0] mdl,
                         input logic hvp);
        @(negedge clk); #1;
        cur_tag = tag;
        code = c; cur_msr = m; sc_level = lev; lp_ext_guest = sel; lp_ail = a;
        lp_ile = ile; hv_ile = hile; model_sel = mdl; hv_present = hvp;
        start = 1'b1;
        @(negedge clk); #1;
        start = 1'b0;
        cur_msr = ~cur_msr;
        code = code + 4'd3;
    endtask

    // Watchdog: a hung run counts as a failure and still reports
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            n_errors++;
            $display("FAIL watchdog expired");
            $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    localparam logic [63:0] XL = B_IR | B_DR;

    initial begin
        repeat (3) @(negedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        cur_tag = "R12";
        chk("reset done", 64'(done), 64'h0);
        chk("reset new_msr", new_msr, 64'h0);
        chk("reset vector", vector, 64'h0);
        chk("reset err", 64'(err), 64'h0);
        checking = 1'b1;

        // R1: all-ones MSR keeps only ME and HV on data storage
        issue("R1", 4'd2, '1, 7'd0, 1'b1, 2'd0, 1'b0, 1'b0, 2'd0, 1'b1);
        issue("R1", 4'd3, B_ME | XL | B_LE, 7'd0, 1'b1, 2'd0, 1'b0, 1'b0, 2'd1, 1'b1);
        // R2: must-be-zero bits removed from the saved image
        issue("R2", 4'd3, 64'hFFFF_FFFF_FFFF_FFFF, 7'd0, 1'b1, 2'd0, 1'b0, 1'b0, 2'd0, 1'b1);
        // R3: external routing by selector and model
        issue("R3", 4'd4, B_RI | XL, 7'd0, 1'b0, 2'd0, 1'b0, 1'b0, 2'd2, 1'b1);
        issue("R3", 4'd4, B_RI | XL, 7'd0, 1'b1, 2'd0, 1'b0, 1'b0, 2'd2, 1'b1);
        issue("R3", 4'd4, B_RI | XL, 7'd0, 1'b0, 2'd0, 1'b0, 1'b0, 2'd0, 1'b1);
        issue("R3", 4'd4, B_RI | XL, 7'd0, 1'b0, 2'd0, 1'b0, 1'b0, 2'd3, 1'b1);
        issue("R3", 4'd4, B_RI, 7'd0, 1'b0, 2'd0, 1'b0, 1'b0, 2'd1, 1'b1);
        // R4: reset and machine check force HV and suppress relocation
        issue("R4", 4'd0, XL | B_HV, 7'd0, 1'b1, 2'd3, 1'b0, 1'b0, 2'd2, 1'b1);
        issue("R4", 4'd1, XL | B_ME | B_HV, 7'd0, 1'b1, 2'd2, 1'b0, 1'b0, 2'd2, 1'b1);
        // R5: hypervisor exceptions and their relocation handling
        issue("R5", 4'd7, XL | B_HV | B_RI, 7'd0, 1'b1, 2'd2, 1'b0, 1'b0, 2'd2, 1'b1);
        issue("R5", 4'd8, XL | B_HV, 7'd0, 1'b1, 2'd3, 1'b0, 1'b0, 2'd2, 1'b1);
        issue("R5", 4'd6, XL | B_HV | B_RI, 7'd0, 1'b1, 2'd2, 1'b0, 1'b0, 2'd2, 1'b1);
        // R6: system call level 1 versus 2
        issue("R6", 4'd5, 64'h0, 7'd1, 1'b1, 2'd0, 1'b0, 1'b0, 2'd0, 1'b1);
        issue("R6", 4'd5, 64'h0, 7'd2, 1'b1, 2'd0, 1'b0, 1'b0, 2'd0, 1'b1);
        // R7: relocation suppressed by translation, transition or model
        issue("R7", 4'd2, B_DR, 7'd0, 1'b1, 2'd3, 1'b0, 1'b0, 2'd2, 1'b1);
        issue("R7", 4'd2, B_IR, 7'd0, 1'b1, 2'd3, 1'b0, 1'b0, 2'd2, 1'b1);
        issue("R7", 4'd5, XL, 7'd1, 1'b1, 2'd3, 1'b0, 1'b0, 2'd2, 1'b1);
        issue("R7", 4'd2, XL, 7'd0, 1'b1, 2'd3, 1'b0, 1'b0, 2'd1, 1'b1);
        // R8: relocation offsets and the reserved value
        issue("R8", 4'd5, XL | B_HV, 7'd1, 1'b1, 2'd3, 1'b0, 1'b0, 2'd2, 1'b1);
        issue("R8", 4'd5, XL, 7'd0, 1'b1, 2'd2, 1'b0, 1'b0, 2'd2, 1'b1);
        issue("R8", 4'd3, XL, 7'd0, 1'b1, 2'd1, 1'b0, 1'b0, 2'd2, 1'b1);
        // R9: endianness per model and target
        issue("R9", 4'd2, 64'h0, 7'd0, 1'b1, 2'd0, 1'b1, 1'b0, 2'd1, 1'b1);
        issue("R9", 4'd0, 64'h0, 7'd0, 1'b1, 2'd0, 1'b1, 1'b1, 2'd1, 1'b1);
        issue("R9", 4'd0, 64'h0, 7'd0, 1'b1, 2'd0, 1'b0, 1'b1, 2'd2, 1'b1);
        issue("R9", 4'd3, 64'h0, 7'd0, 1'b1, 2'd0, 1'b1, 1'b0, 2'd2, 1'b1);
        issue("R9", 4'd3, 64'h0, 7'd0, 1'b1, 2'd0, 1'b1, 1'b1, 2'd0, 1'b1);
        // R10: errors for missing hypervisor support and unknown codes
        issue("R10", 4'd6, 64'h0, 7'd0, 1'b1, 2'd0, 1'b0, 1'b0, 2'd2, 1'b0);
        issue("R10", 4'd12, 64'h0, 7'd0, 1'b1, 2'd0, 1'b0, 1'b0, 2'd2, 1'b1);
        issue("R10", 4'd4, 64'h0, 7'd0, 1'b1, 2'd0, 1'b0, 1'b0, 2'd2, 1'b0);
        // R11: base vector of every code
        for (int k = 0; k < 16; k++)
            issue("R11", 4'(k), 64'h0, 7'd0, 1'b1, 2'd0, 1'b0, 1'b0, 2'd0, 1'b1);
        // R12: back-to-back starts and long holds
        @(negedge clk); #1;
        cur_tag = "R12";
        code = 4'd6; cur_msr = B_HV; model_sel = 2'd2; hv_present = 1'b1; start = 1'b1;
        @(negedge clk); #1 code = 4'd0;
        @(negedge clk); #1 start = 1'b0; cur_msr = '1; code = 4'd9;
        repeat (5) @(negedge clk);
        // Random traffic
        for (int i = 0; i < 600; i++) begin
            logic [63:0] rm;
            rm = {$urandom, $urandom};
            if (i % 3 == 0) rm = rm | XL;
            issue("R1", 4'($urandom_range(0, 9)), rm, 7'($urandom_range(0, 2)),
                  1'($urandom), 2'($urandom), 1'($urandom), 1'($urandom),
                  2'($urandom), ($urandom_range(0, 7) != 0));
        end
        repeat (3) @(negedge clk);
        $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule